// File: doc/BRIEF.md
# Radix-2 Signed-Digit Adder/Subtractor

This block adds or subtracts two N-digit numbers held in radix-2 redundant signed-digit form. Every digit is one of -1, 0 or +1. It is stored as a two-bit code: a positive bit and a negative bit. A number's value is its positive bit vector minus its negative bit vector. Because the representation is redundant, a transfer never travels more than two digit positions, so the logic depth is the same for any width.

The block is meant to sit inside wide arithmetic datapaths that keep values in carry-free form between operations. One control input selects subtraction. Subtraction negates the second operand by swapping the two bits of each of its digits, so it needs no extra adder. The sum has N+1 digits and is captured in a register on the rising clock edge.

Top module: `rsd_adder`

## Requirements
- R1: Digit i of a vector occupies bits [2i+1:2i]. Bit 2i+1 is the positive part and bit 2i is the negative part. The code 2'b10 means +1, 2'b01 means -1 and 2'b00 means 0. The value of a vector is the sum of digit_i * 2^i.
- R2: With `sub_en` low at a rising edge, `sum_q` decodes after that edge to value(op_a) + value(op_b).
- R3: With `sub_en` high at a rising edge, `sum_q` decodes after that edge to value(op_a) - value(op_b).
- R4: An input digit with the code 2'b11 counts as digit 0.
- R5: No digit of `sum_q` ever carries the code 2'b11.
- R6: While `rst_n` is low, `sum_q` is all zeros. `sum_q` is still all zeros at the first edge after release.
- R7: Output digit i depends only on input digits i, i-1 and i-2 and on `sub_en`. Changing one input digit k changes no output digit outside positions k to k+2.
- R8: Output digit N takes the final transfer. Adding two all-(+1) operands gives digit N = +1 (code 2'b10).
- R9: `sum_q` changes only at a rising edge. If the inputs are held steady across an edge, `sum_q` does not change at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 2*N | First operand, N signed digits |
| op_b | input | 2*N | Second operand, N signed digits |
| sub_en | input | 1 | High: subtract op_b; low: add |
| sum_q | output | 2*(N+1) | Registered N+1-digit signed-digit result |

## Verification
The bench draws random operands with random redundant encodings, including the illegal 2'b11 code. If the unused code were decoded as anything other than zero, the decoded sums would shift. If subtraction swapped the wrong bits or was left out, the difference checks would fail. Operands made entirely of +1 digits, and +1 digits minus -1 digits, drive a transfer out of every position. A design that dropped the extra top digit, or picked the wrong interim digit when the position below is negative, would lose value there or produce an illegal 2'b11 code. A locality test changes one input digit and confirms that no output digit more than two places above it changes, which catches any transfer that travels further than intended.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

    typedef logic [1:0] sd_code_t;

    localparam sd_code_t SD_ZERO = 2'b00;
    localparam sd_code_t SD_POS  = 2'b10;
    localparam sd_code_t SD_NEG  = 2'b01;

    // Value of one digit code; the unused code 11 counts as zero.
    function automatic logic signed [2:0] sd_val(input sd_code_t c);
        logic signed [2:0] v;
        unique case (c)
            SD_POS:  v = 3'sd1;
            SD_NEG:  v = -3'sd1;
            default: v = 3'sd0;
        endcase
        return v;
    endfunction

    // Code for a digit value in {-1,0,+1}; anything else maps to zero.
    function automatic sd_code_t sd_enc(input logic signed [2:0] v);
        sd_code_t c;
        if (v == 3'sd1)
            c = SD_POS;
        else if (v == -3'sd1)
            c = SD_NEG;
        else
            c = SD_ZERO;
        return c;
    endfunction

endpackage

// File: rtl/rsd_operand_prep.sv
module rsd_operand_prep #(
    parameter int N = 16
) (
    input  logic [2*N-1:0] raw_code,
    input  logic           negate,
    output logic [N-1:0]   pos_o,
    output logic [N-1:0]   neg_o
);
    for (genvar i = 0; i < N; i++) begin : g_digit
        logic p_in;
        logic n_in;
        logic legal;
        assign p_in  = raw_code[2*i+1];
        assign n_in  = raw_code[2*i];
        // 11 is folded to zero; negation swaps the two parts.
        assign legal    = p_in ^ n_in;
        assign pos_o[i] = legal & (negate ? n_in : p_in);
        assign neg_o[i] = legal & (negate ? p_in : n_in);
    end

endmodule

// File: rtl/rsd_xfer_stage.sv
module rsd_xfer_stage
    import rsd_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0]   a_pos,
    input  logic [N-1:0]   a_neg,
    input  logic [N-1:0]   b_pos,
    input  logic [N-1:0]   b_neg,
    output logic [2*N-1:0] w_code,
    output logic [2*N+1:0] t_code
);
    logic signed [2:0] psum [N];
    logic [N-1:0]      below_neg;

    assign t_code[1:0] = SD_ZERO;

    for (genvar i = 0; i < N; i++) begin : g_pos
        assign psum[i] = $signed({2'b00, a_pos[i]}) - $signed({2'b00, a_neg[i]})
                       + $signed({2'b00, b_pos[i]}) - $signed({2'b00, b_neg[i]});

        if (i == 0) begin : g_lsd
            assign below_neg[i] = 1'b0;
        end else begin : g_upper
            assign below_neg[i] = psum[i-1][2];
        end

        logic signed [2:0] t_v;
        logic signed [2:0] w_v;

        always_comb begin
            t_v = 3'sd0;
            w_v = 3'sd0;
            if (psum[i] == 3'sd2) begin
                t_v = 3'sd1;
            end else if (psum[i] == -3'sd2) begin
                t_v = -3'sd1;
            end else if (psum[i] == 3'sd1) begin
                if (below_neg[i]) begin
                    w_v = 3'sd1;
                end else begin
                    t_v = 3'sd1;
                    w_v = -3'sd1;
                end
            end else if (psum[i] == -3'sd1) begin
                if (below_neg[i]) begin
                    t_v = -3'sd1;
                    w_v = 3'sd1;
                end else begin
                    w_v = -3'sd1;
                end
            end
        end

        assign w_code[2*i +: 2]     = sd_enc(w_v);
        assign t_code[2*(i+1) +: 2] = sd_enc(t_v);
    end

endmodule

// File: rtl/rsd_sum_stage.sv
module rsd_sum_stage
    import rsd_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [2*N-1:0] w_code,
    input  logic [2*N+1:0] t_code,
    output logic [2*N+1:0] sum_code
);
    for (genvar i = 0; i < N; i++) begin : g_dig
        logic signed [2:0] s_v;
        assign s_v = sd_val(w_code[2*i +: 2]) + sd_val(t_code[2*i +: 2]);
        assign sum_code[2*i +: 2] = sd_enc(s_v);
    end

    assign sum_code[2*N +: 2] = t_code[2*N +: 2];

endmodule

// File: rtl/rsd_adder.sv
module rsd_adder
    import rsd_pkg::*;
#(
    parameter int N = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2*N-1:0]   op_a,
    input  logic [2*N-1:0]   op_b,
    input  logic             sub_en,
    output logic [2*N+1:0]   sum_q
);
    localparam int OUT_W = 2 * (N + 1);

    logic [N-1:0]     a_pos, a_neg, b_pos, b_neg;
    logic [2*N-1:0]   w_code;
    logic [2*N+1:0]   t_code;
    logic [OUT_W-1:0] sum_d;

    rsd_operand_prep #(.N(N)) u_prep_a (
        .raw_code (op_a),
        .negate   (1'b0),
        .pos_o    (a_pos),
        .neg_o    (a_neg)
    );

    rsd_operand_prep #(.N(N)) u_prep_b (
        .raw_code (op_b),
        .negate   (sub_en),
        .pos_o    (b_pos),
        .neg_o    (b_neg)
    );

    rsd_xfer_stage #(.N(N)) u_xfer (
        .a_pos  (a_pos),
        .a_neg  (a_neg),
        .b_pos  (b_pos),
        .b_neg  (b_neg),
        .w_code (w_code),
        .t_code (t_code)
    );

    rsd_sum_stage #(.N(N)) u_sum (
        .w_code   (w_code),
        .t_code   (t_code),
        .sum_code (sum_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sum_q <= '0;
        else
            sum_q <= sum_d;
    end

endmodule

// File: rtl/rsd_adder_chk.sv
module rsd_adder_chk #(
    parameter int N = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic [2*N-1:0] op_a,
    input logic [2*N-1:0] op_b,
    input logic           sub_en,
    input logic [2*N+1:0] sum_q
);
    localparam int VW = N + 3;

    function automatic logic signed [VW-1:0] decode(input logic [2*N+1:0] v, input int nd);
        logic signed [VW-1:0] r;
        r = '0;
        for (int i = N; i >= 0; i--) begin
            if (i < nd) begin
                r = r <<< 1;
                if (v[2*i+1] && !v[2*i])
                    r = r + 1;
                else if (!v[2*i+1] && v[2*i])
                    r = r - 1;
            end
        end
        return r;
    endfunction

    function automatic logic has_bad(input logic [2*N+1:0] v);
        logic b;
        b = 1'b0;
        for (int i = 0; i <= N; i++)
            b = b | (v[2*i+1] & v[2*i]);
        return b;
    endfunction

    logic signed [VW-1:0] va, vb, vout, want;
    assign va   = decode({2'b00, op_a}, N);
    assign vb   = decode({2'b00, op_b}, N);
    assign vout = decode(sum_q, N + 1);
    assign want = sub_en ? (va - vb) : (va + vb);

    // R2
    add_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sub_en |=> vout == $past(want));

    // R3
    sub_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sub_en |=> vout == $past(want));

    // R5
    no_bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !has_bad(sum_q));

    // R6
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> sum_q == '0);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(op_a) && $stable(op_b) && $stable(sub_en))
        |=> $stable(sum_q));

endmodule

bind rsd_adder rsd_adder_chk #(.N(N)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_a   (op_a),
    .op_b   (op_b),
    .sub_en (sub_en),
    .sum_q  (sum_q)
);

// File: tb/tb_rsd_adder.sv
`timescale 1ns/1ps
module tb_rsd_adder;
    localparam int N = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [2*N-1:0] op_a = '0;
    logic [2*N-1:0] op_b = '0;
    logic           sub_en = 1'b0;
    logic [2*N+1:0] sum_q;

    int compared = 0;
    int mismatched = 0;

    always #10 clk = ~clk;

    rsd_adder #(.N(N)) dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .sub_en(sub_en), .sum_q(sum_q)
    );

    function automatic longint dec(input logic [2*N+1:0] v, input int nd);
        longint r = 0;
        for (int i = nd - 1; i >= 0; i--) begin
            r = r * 2;
            if (v[2*i+1] && !v[2*i]) r = r + 1;
            else if (!v[2*i+1] && v[2*i]) r = r - 1;
        end
        return r;
    endfunction

    function automatic logic [2*N-1:0] rand_digits(input bit allow_bad);
        logic [2*N-1:0] v;
        for (int i = 0; i < N; i++) begin
            logic [1:0] c;
            c = 2'($urandom_range(3));
            if (!allow_bad && c == 2'b11) c = 2'b00;
            v[2*i +: 2] = c;
        end
        return v;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive at a falling edge, compare after the next rising edge.
    task automatic step(input logic [2*N-1:0] a, input logic [2*N-1:0] b, input logic s,
                        input string req);
        longint ev;
        int bad;
        op_a = a; op_b = b; sub_en = s;
        ev = s ? dec({2'b00, a}, N) - dec({2'b00, b}, N)
               : dec({2'b00, a}, N) + dec({2'b00, b}, N);
        @(negedge clk);
        check(req, dec(sum_q, N + 1), ev);
        bad = 0;
        for (int i = 0; i <= N; i++) if (sum_q[2*i +: 2] == 2'b11) bad++;
        check("R5", bad, 0);
    endtask

    initial begin
        #(200000 * 20);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [2*N-1:0] all_pos, all_neg, all_bad, a0, b0;
        logic [2*N+1:0] first, hold;
        all_pos = '0; all_neg = '0; all_bad = '1;
        for (int i = 0; i < N; i++) begin
            all_pos[2*i +: 2] = 2'b10;
            all_neg[2*i +: 2] = 2'b01;
        end

        // R6: reset state
        repeat (2) @(negedge clk);
        check("R6", longint'(sum_q), 0);
        rst_n = 1'b1;
        check("R6", longint'(sum_q), 0);

        // R1 R2: simple values
        step({{(2*N-4){1'b0}}, 4'b1001}, {{(2*N-2){1'b0}}, 2'b10}, 1'b0, "R1");
        step('0, '0, 1'b0, "R2");

        // R8: transfer out of every position
        step(all_pos, all_pos, 1'b0, "R8");
        check("R8", longint'(sum_q[2*N +: 2]), 2);
        step(all_pos, all_neg, 1'b1, "R8");
        step(all_neg, all_neg, 1'b0, "R8");
        check("R8", longint'(sum_q[2*N +: 2]), 1);

        // R4: code 11 counts as zero
        step(all_bad, all_pos, 1'b0, "R4");
        step(all_pos, all_bad, 1'b1, "R4");
        step(all_bad, all_bad, 1'b0, "R4");

        // R2 R3: random redundant operands
        for (int n = 0; n < 600; n++)
            step(rand_digits(n % 3 == 0), rand_digits(n % 5 == 0), n[0],
                 n[0] ? "R3" : "R2");

        // R9: inputs held, output stable
        a0 = rand_digits(1'b0); b0 = rand_digits(1'b0);
        step(a0, b0, 1'b1, "R3");
        hold = sum_q;
        @(negedge clk);
        check("R9", longint'(sum_q != hold), 0);

        // R7: one changed digit touches only positions k..k+2
        for (int k = 0; k < N; k++) begin
            int outside;
            a0 = rand_digits(1'b0); b0 = rand_digits(1'b0);
            step(a0, b0, k[0], "R2");
            first = sum_q;
            a0[2*k +: 2] = (a0[2*k +: 2] == 2'b10) ? 2'b01 : 2'b10;
            step(a0, b0, k[0], "R3");
            outside = 0;
            for (int j = 0; j <= N; j++)
                if ((j < k || j > k + 2) && sum_q[2*j +: 2] != first[2*j +: 2]) outside++;
            check("R7", outside, 0);
        end

        // R6: reset mid-run clears output
        step(all_pos, all_pos, 1'b0, "R2");
        rst_n = 1'b0;
        @(negedge clk);
        check("R6", longint'(sum_q), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule